// File: doc/BRIEF.md
# Touch Panel Switch and Power Manager

This block sits between the conversion sequencer of a resistive touch-panel converter and its analog front end. It takes the channel address, the reference-mode bit and the two power-down bits from the control word. From them it drives the enables for the four plate driver switches, a one-hot analog input select, the reference-source select, the internal reference, the converter's power and the battery input divider. Every enable is timed by phase strobes from the sequencer: start bit seen, acquisition begins, hold begins, conversion done, and chip-select rise.

A five-state machine follows the conversion. In `ST_IDLE` the converter sleeps unless the latched power code keeps it awake. A start strobe moves to `ST_ARM`, where the converter powers up. The acquire strobe moves to `ST_ACQ` and latches the address and mode. The hold strobe moves to `ST_CONV` and latches the power code. The done strobe returns to `ST_IDLE`, or goes to `ST_KEEP` when drivers must stay on. `ST_KEEP` leaves for `ST_ACQ` on the next acquire strobe, or for `ST_IDLE` when the live fields differ from the latched ones. A chip-select rise sends any state except `ST_IDLE` back to `ST_IDLE`.

Top module: `tpm_switch_mgr`

## Requirements
- R1: After reset the power code reads 00, so only the Y- switch is on (`sw_en`=4'b1000), and `ref_on`, `adc_on`, `bat_div_on`, `mux_sel` and `ref_sel` are all 0.
- R2: The `sw_en` bits are 0=X+, 1=X-, 2=Y+, 3=Y-. While drivers are active, address 001 turns on Y+ and Y- (4'b1100), address 101 turns on X+ and X- (4'b0011), and addresses 011 and 100 turn on X- and Y+ (4'b0110). Every other address turns on no driver.
- R3: In single-ended mode (`cfg_se`=1) the drivers are on only in `ST_ACQ` and go off at the hold strobe.
- R4: In differential mode (`cfg_se`=0) the drivers stay on through `ST_CONV`. They go off at the done strobe unless R7 applies.
- R5: `ref_sel` is 0 for VREF/GND in single-ended mode. In differential mode it is 1 (Y+/Y-) for address 001, 2 (X+/X-) for address 101, and 3 (Y+/X-) for addresses 011 and 100. It is nonzero only in `ST_ACQ`, `ST_CONV` and `ST_KEEP`.
- R6: In differential mode, addresses 000, 010, 110 and 111 are illegal. They enable no driver, no mux input and no battery divider, and `ref_sel` stays 0.
- R7: With power code 11, a differential conversion on a driving address keeps its drivers on after the done strobe. They go off at a chip-select rise, or one cycle after the live address, mode or power code differs from the latched value.
- R8: With power code 00, `ref_on` is 0. `adc_on` drops at the done strobe, or at a chip-select rise if that comes first. `adc_on` rises at the start strobe, and the Y- switch alone is on in `ST_IDLE`.
- R9: `ref_on` equals power-code bit 1. `adc_on` is on at all times when bit 0 is set. When bit 0 is clear, `adc_on` is on only from the start strobe to the end of the conversion.
- R10: A new power code is taken only at the hold strobe. Until then `ref_on` and `adc_on` follow the previous code.
- R11: `bat_div_on` is 1 only in `ST_ACQ` with address 010 in single-ended mode.
- R12: At most one high-side switch (X+, Y+) and at most one low-side switch (X-, Y-) is on in any cycle.
- R13: `mux_sel` is one-hot and nonzero only in `ST_ACQ`. Its bits are 0=X+, 1=Y+, 2=Y-, 3=battery, 4=aux, 5=temperature bias 1, 6=temperature bias 2. The addresses map 001 and 011 to X+, 101 to Y+, 100 to Y-, 010 to battery, 110 to aux, 000 to bias 1 and 111 to bias 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_chan | input | 3 | Channel address field of the control word |
| cfg_se | input | 1 | 1 = single-ended reference, 0 = differential |
| cfg_pd | input | 2 | Power-down code |
| start_stb | input | 1 | Start bit detected |
| acq_stb | input | 1 | Acquisition begins |
| hold_stb | input | 1 | Hold begins, control word complete |
| done_stb | input | 1 | Conversion finished |
| cs_rise | input | 1 | Chip select went inactive |
| sw_en | output | 4 | Plate driver switch enables |
| mux_sel | output | 7 | One-hot analog input select |
| ref_sel | output | 2 | Reference source select |
| ref_on | output | 1 | Internal reference enable |
| adc_on | output | 1 | Converter power enable |
| bat_div_on | output | 1 | Battery divider enable |

## Verification
The bench steps through every address, mode and power code in turn. At each phase it compares the switch, mux, reference and power outputs with a model that tracks which power code was last committed. This catches a design that commits the power code at acquisition instead of at hold, or that leaves single-ended drivers on into the conversion. It also catches a design that drives a plate for an illegal differential address. Directed cases abort a conversion with a chip-select rise under power code 00, where a design that waits for the done strobe would keep the converter powered. They also change the address while drivers are held on under code 11, where a design that never compares the live fields would leave the panel driven.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
    localparam int SW_N  = 4;
    localparam int MUX_N = 7;

    // switch bit positions
    localparam int SW_XP = 0;
    localparam int SW_XN = 1;
    localparam int SW_YP = 2;
    localparam int SW_YN = 3;

    // mux bit positions
    localparam int MX_XP = 0;
    localparam int MX_YP = 1;
    localparam int MX_YN = 2;
    localparam int MX_BAT = 3;
    localparam int MX_AUX = 4;
    localparam int MX_T0 = 5;
    localparam int MX_T1 = 6;

    localparam logic [2:0] CH_T0  = 3'b000;
    localparam logic [2:0] CH_XP  = 3'b001;
    localparam logic [2:0] CH_BAT = 3'b010;
    localparam logic [2:0] CH_Z1  = 3'b011;
    localparam logic [2:0] CH_Z2  = 3'b100;
    localparam logic [2:0] CH_YP  = 3'b101;
    localparam logic [2:0] CH_AUX = 3'b110;
    localparam logic [2:0] CH_T1  = 3'b111;

    localparam logic [1:0] PD_PEN  = 2'b00;
    localparam logic [1:0] PD_HOLD = 2'b11;

    localparam logic [1:0] REF_VREF = 2'd0;
    localparam logic [1:0] REF_YPL  = 2'd1;
    localparam logic [1:0] REF_XPL  = 2'd2;
    localparam logic [1:0] REF_ZPR  = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_ACQ,
        ST_CONV,
        ST_KEEP
    } tpm_state_e;

    function automatic int mux_index(input logic [2:0] ch);
        case (ch)
            CH_T0:   return MX_T0;
            CH_XP:   return MX_XP;
            CH_BAT:  return MX_BAT;
            CH_Z1:   return MX_XP;
            CH_Z2:   return MX_YN;
            CH_YP:   return MX_YP;
            CH_AUX:  return MX_AUX;
            default: return MX_T1;
        endcase
    endfunction
endpackage

// File: rtl/tpm_route_dec.sv
module tpm_route_dec
    import tpm_pkg::*;
#(
    parameter int SWN = SW_N,
    parameter int MXN = MUX_N
) (
    input  logic [2:0]     chan,
    input  logic           se,
    output logic           legal,
    output logic [SWN-1:0] drv,
    output logic [MXN-1:0] mux,
    output logic [1:0]     refs
);
    logic plate_ch;

    always_comb begin
        plate_ch = (chan == CH_XP) || (chan == CH_YP) ||
                   (chan == CH_Z1) || (chan == CH_Z2);
        legal = se || plate_ch;
    end

    always_comb begin
        drv = '0;
        if (legal) begin
            unique case (chan)
                CH_XP: begin
                    drv[SW_YP] = 1'b1;
                    drv[SW_YN] = 1'b1;
                end
                CH_YP: begin
                    drv[SW_XP] = 1'b1;
                    drv[SW_XN] = 1'b1;
                end
                CH_Z1, CH_Z2: begin
                    drv[SW_XN] = 1'b1;
                    drv[SW_YP] = 1'b1;
                end
                default: drv = '0;
            endcase
        end
    end

    generate
        for (genvar i = 0; i < MXN; i++) begin : g_mux
            assign mux[i] = legal && (mux_index(chan) == i);
        end
    endgenerate

    always_comb begin
        refs = REF_VREF;
        if (!se) begin
            unique case (chan)
                CH_XP:        refs = REF_YPL;
                CH_YP:        refs = REF_XPL;
                CH_Z1, CH_Z2: refs = REF_ZPR;
                default:      refs = REF_VREF;
            endcase
        end
    end
endmodule

// File: rtl/tpm_power_ctl.sv
module tpm_power_ctl
    import tpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take_pd,
    input  logic [1:0] pd_in,
    input  logic       conv_active,
    output logic [1:0] pd_q,
    output logic       ref_on,
    output logic       adc_on
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            pd_q <= PD_PEN;
        else if (take_pd)
            pd_q <= pd_in;
    end

    always_comb begin
        ref_on = pd_q[1];
        adc_on = pd_q[0] || conv_active;
    end
endmodule

// File: rtl/tpm_switch_mgr.sv
module tpm_switch_mgr
    import tpm_pkg::*;
#(
    parameter int SWN = SW_N,
    parameter int MXN = MUX_N
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     cfg_chan,
    input  logic           cfg_se,
    input  logic [1:0]     cfg_pd,
    input  logic           start_stb,
    input  logic           acq_stb,
    input  logic           hold_stb,
    input  logic           done_stb,
    input  logic           cs_rise,
    output logic [SWN-1:0] sw_en,
    output logic [MXN-1:0] mux_sel,
    output logic [1:0]     ref_sel,
    output logic           ref_on,
    output logic           adc_on,
    output logic           bat_div_on
);
    localparam logic [SWN-1:0] PEN_MASK = SWN'(1) << SW_YN;

    tpm_state_e st_q, st_nx;
    logic [2:0] chan_q;
    logic       se_q;
    logic [1:0] pd_q;
    logic       legal;
    logic [SWN-1:0] drv;
    logic [MXN-1:0] mux;
    logic [1:0] refs;
    logic take_addr, take_pd, keep_ok, cfg_moved, conv_active, drv_on;

    tpm_route_dec #(.SWN(SWN), .MXN(MXN)) u_dec (
        .chan  (chan_q),
        .se    (se_q),
        .legal (legal),
        .drv   (drv),
        .mux   (mux),
        .refs  (refs)
    );

    always_comb begin
        take_addr   = acq_stb && !cs_rise && (st_q == ST_ARM || st_q == ST_KEEP);
        take_pd     = hold_stb && !cs_rise && (st_q == ST_ACQ);
        keep_ok     = (pd_q == PD_HOLD) && !se_q && legal && (drv != '0);
        cfg_moved   = (cfg_chan != chan_q) || (cfg_se != se_q) || (cfg_pd != pd_q);
        conv_active = (st_q == ST_ARM) || (st_q == ST_ACQ) || (st_q == ST_CONV);
    end

    tpm_power_ctl u_pwr (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_pd     (take_pd),
        .pd_in       (cfg_pd),
        .conv_active (conv_active),
        .pd_q        (pd_q),
        .ref_on      (ref_on),
        .adc_on      (adc_on)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= CH_T0;
            se_q   <= 1'b1;
        end else if (take_addr) begin
            chan_q <= cfg_chan;
            se_q   <= cfg_se;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: if (start_stb) st_nx = ST_ARM;
            ST_ARM: begin
                if (cs_rise)      st_nx = ST_IDLE;
                else if (acq_stb) st_nx = ST_ACQ;
            end
            ST_ACQ: begin
                if (cs_rise)       st_nx = ST_IDLE;
                else if (hold_stb) st_nx = ST_CONV;
            end
            ST_CONV: begin
                if (cs_rise)       st_nx = ST_IDLE;
                else if (done_stb) st_nx = keep_ok ? ST_KEEP : ST_IDLE;
            end
            ST_KEEP: begin
                if (cs_rise)        st_nx = ST_IDLE;
                else if (acq_stb)   st_nx = ST_ACQ;
                else if (cfg_moved) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        drv_on = (st_q == ST_ACQ) || (st_q == ST_KEEP) ||
                 ((st_q == ST_CONV) && !se_q);
        if (drv_on)
            sw_en = drv;
        else if (st_q == ST_IDLE && pd_q == PD_PEN)
            sw_en = PEN_MASK;
        else
            sw_en = '0;
        mux_sel    = (st_q == ST_ACQ) ? mux : '0;
        ref_sel    = ((st_q == ST_ACQ) || (st_q == ST_CONV) || (st_q == ST_KEEP))
                     ? refs : REF_VREF;
        bat_div_on = (st_q == ST_ACQ) && se_q && (chan_q == CH_BAT);
    end
endmodule

// File: rtl/tpm_switch_mgr_chk.sv
module tpm_switch_mgr_chk
    import tpm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start_stb,
    input logic             hold_stb,
    input logic [SW_N-1:0]  sw_en,
    input logic [MUX_N-1:0] mux_sel,
    input logic             ref_on,
    input logic             adc_on,
    input logic             bat_div_on
);
    // R12: one high-side and one low-side switch at most
    a_r12_high_side: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sw_en[SW_XP], sw_en[SW_YP]}));
    a_r12_low_side: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sw_en[SW_XN], sw_en[SW_YN]}));
    // R2: only the documented switch patterns appear
    a_r2_patterns: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en == 4'b0000) || (sw_en == 4'b1100) || (sw_en == 4'b0011) ||
        (sw_en == 4'b0110) || (sw_en == 4'b1000));
    // R13: input select is one-hot
    a_r13_mux_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mux_sel));
    // R11: divider only with the battery input selected
    a_r11_bat_mux: assert property (@(posedge clk) disable iff (!rst_n)
        bat_div_on |-> mux_sel[MX_BAT]);
    // R10: reference enable moves only after a hold strobe
    a_r10_ref_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_on) |-> $past(hold_stb));
    // R8: converter powers up only on start or a new code at hold
    a_r8_adc_wake: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_on) |-> ($past(start_stb) || $past(hold_stb)));
endmodule

bind tpm_switch_mgr tpm_switch_mgr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_stb  (start_stb),
    .hold_stb   (hold_stb),
    .sw_en      (sw_en),
    .mux_sel    (mux_sel),
    .ref_on     (ref_on),
    .adc_on     (adc_on),
    .bat_div_on (bat_div_on)
);

// File: tb/tpm_switch_mgr_test.sv
module tpm_switch_mgr_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] cfg_chan = 3'b000;
    logic cfg_se = 1'b1;
    logic [1:0] cfg_pd = 2'b00;
    logic start_stb = 1'b0, acq_stb = 1'b0, hold_stb = 1'b0, done_stb = 1'b0, cs_rise = 1'b0;
    logic [3:0] sw_en;
    logic [6:0] mux_sel;
    logic [1:0] ref_sel;
    logic ref_on, adc_on, bat_div_on;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tpm_switch_mgr uut (
        .clk(clk), .rst_n(rst_n), .cfg_chan(cfg_chan), .cfg_se(cfg_se), .cfg_pd(cfg_pd),
        .start_stb(start_stb), .acq_stb(acq_stb), .hold_stb(hold_stb),
        .done_stb(done_stb), .cs_rise(cs_rise), .sw_en(sw_en), .mux_sel(mux_sel),
        .ref_sel(ref_sel), .ref_on(ref_on), .adc_on(adc_on), .bat_div_on(bat_div_on)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic eq(input string req, input string what, input int act, input int exp);
        check(act == exp, req, what, act, exp);
    endtask

    // one-cycle strobe: 0 start,1 acq,2 hold,3 done,4 cs rise
    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: start_stb = 1'b1;
            1: acq_stb = 1'b1;
            2: hold_stb = 1'b1;
            3: done_stb = 1'b1;
            default: cs_rise = 1'b1;
        endcase
        @(negedge clk);
        start_stb = 1'b0; acq_stb = 1'b0; hold_stb = 1'b0; done_stb = 1'b0; cs_rise = 1'b0;
    endtask

    function automatic bit legal_of(input logic [2:0] ch, input logic se);
        return se || ch == 3'b001 || ch == 3'b101 || ch == 3'b011 || ch == 3'b100;
    endfunction

    function automatic int drv_of(input logic [2:0] ch, input logic se);
        if (!legal_of(ch, se)) return 0;
        case (ch)
            3'b001: return 12;
            3'b101: return 3;
            3'b011, 3'b100: return 6;
            default: return 0;
        endcase
    endfunction

    function automatic int mux_of(input logic [2:0] ch, input logic se);
        int idx;
        if (!legal_of(ch, se)) return 0;
        case (ch)
            3'b000: idx = 5;
            3'b001: idx = 0;
            3'b010: idx = 3;
            3'b011: idx = 0;
            3'b100: idx = 2;
            3'b101: idx = 1;
            3'b110: idx = 4;
            default: idx = 6;
        endcase
        return 1 << idx;
    endfunction

    function automatic int ref_of(input logic [2:0] ch, input logic se);
        if (se) return 0;
        case (ch)
            3'b001: return 1;
            3'b101: return 2;
            3'b011, 3'b100: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic int idle_sw(input logic [1:0] pd);
        return (pd == 2'b00) ? 8 : 0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [1:0] pd_m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        eq("R1", "sw_en", sw_en, 8);
        eq("R1", "adc_on", adc_on, 0);
        eq("R1", "ref_on", ref_on, 0);
        eq("R1", "mux_sel", mux_sel, 0);
        eq("R1", "ref_sel", ref_sel, 0);
        eq("R1", "bat_div_on", bat_div_on, 0);
        pd_m = 2'b00;

        for (int p = 0; p < 4; p++) begin
            for (int s = 0; s < 2; s++) begin
                for (int c = 0; c < 8; c++) begin
                    logic [2:0] ch;
                    logic se;
                    bit keep;
                    ch = 3'(c); se = 1'(s);
                    @(negedge clk);
                    cfg_chan = ch; cfg_se = se; cfg_pd = 2'(p);
                    // R9 idle power from previous code
                    eq("R9", "idle adc_on", adc_on, pd_m[0]);
                    eq("R8", "idle sw_en", sw_en, idle_sw(pd_m));
                    pulse(0);
                    eq("R8", "adc_on after start", adc_on, 1);
                    eq("R3", "sw_en armed", sw_en, 0);
                    pulse(1);
                    eq("R2", "sw_en acquire", sw_en, drv_of(ch, se));
                    eq("R13", "mux_sel", mux_sel, mux_of(ch, se));
                    eq("R5", "ref_sel acquire", ref_sel, ref_of(ch, se));
                    eq("R11", "bat_div_on", bat_div_on, (se && ch == 3'b010) ? 1 : 0);
                    eq("R10", "ref_on before hold", ref_on, pd_m[1]);
                    if (!legal_of(ch, se)) eq("R6", "illegal sw_en", sw_en, 0);
                    pulse(2);
                    pd_m = 2'(p);
                    eq("R10", "ref_on after hold", ref_on, pd_m[1]);
                    eq(se ? "R3" : "R4", "sw_en convert", sw_en, se ? 0 : drv_of(ch, se));
                    eq("R13", "mux_sel convert", mux_sel, 0);
                    eq("R11", "bat_div_on convert", bat_div_on, 0);
                    pulse(3);
                    keep = (pd_m == 2'b11) && !se && drv_of(ch, se) != 0;
                    eq(keep ? "R7" : "R4", "sw_en after done", sw_en,
                       keep ? drv_of(ch, se) : idle_sw(pd_m));
                    eq("R9", "adc_on after done", adc_on, keep ? 1 : pd_m[0]);
                    eq("R9", "ref_on after done", ref_on, pd_m[1]);
                    pulse(4);
                    eq("R7", "sw_en after cs rise", sw_en, idle_sw(pd_m));
                end
            end
        end

        // R7: field change releases held drivers
        @(negedge clk);
        cfg_chan = 3'b001; cfg_se = 1'b0; cfg_pd = 2'b11;
        pulse(0); pulse(1); pulse(2); pulse(3);
        eq("R7", "held sw_en", sw_en, 12);
        cfg_chan = 3'b101;
        @(negedge clk);
        eq("R7", "sw_en after address change", sw_en, 0);
        eq("R7", "adc_on stays", adc_on, 1);

        // R8: chip-select rise during conversion with code 00
        @(negedge clk);
        cfg_chan = 3'b101; cfg_se = 1'b0; cfg_pd = 2'b00;
        pulse(0); pulse(1); pulse(2);
        eq("R8", "ref_on code 00", ref_on, 0);
        eq("R8", "adc_on converting", adc_on, 1);
        pulse(4);
        eq("R8", "adc_on after abort", adc_on, 0);
        eq("R8", "pen switch after abort", sw_en, 8);
        eq("R5", "ref_sel idle", ref_sel, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule